// File: doc/BRIEF.md
# Scoreboarded Warp Issue Scheduler

This block decides which warp of a multithreaded core sends its next instruction to the dispatch stage. Each of up to 24 resident warps owns one instruction buffer slot. The fetch side writes at most one instruction per cycle into the slot of the warp it names. A slot that still holds an unissued instruction refuses a new one.

For every warp the block keeps one pending bit per architectural register. When an instruction issues, its destination register is marked pending. A writeback report from an execution or memory pipeline names a warp and a register, and clears that mark. A buffered instruction is eligible only when none of its three registers (destination and both sources) is pending. This covers read-after-write and write-after-write hazards. A warp waiting on a slow load therefore does not hold back other warps.

At most one eligible instruction issues per cycle. The choice favours the slot that has waited longest, using a saturating age per slot. Among slots of equal age, the first one found from a rotating round-robin pointer wins. Sending one instruction across all 32 lanes takes four cycles, so after an issue the dispatch stage accepts nothing for the next three cycles.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset no instruction issues, every slot is empty (`fetchReady` is 1 for any valid warp id) and no register is pending.
- R2: `fetchReady` is 1 exactly when the slot of `fetchWarp` is empty. A fetch is taken only when `fetchValid` and `fetchReady` are both 1. A fetch offered to a full slot is ignored and leaves the held instruction unchanged.
- R3: An eligible instruction that is chosen appears on `issueValid`/`issueWarp`/`issueOp`/`issueDst` one clock edge later. An instruction fetched at edge N issues at the earliest at edge N+1, and its slot is empty again after that edge.
- R4: An instruction whose source register is pending for its own warp does not issue until a writeback clears that register.
- R5: An instruction whose destination register is pending for its own warp does not issue until a writeback clears it.
- R6: A writeback (`wbValid`, `wbWarp`, `wbReg`) clears the pending bit of that register for that warp only. Writebacks to other warps have no effect on it.
- R7: When an issue sets a pending bit and a writeback clears the same bit at the same edge, the bit ends up set.
- R8: Issues are at least 4 cycles apart (`issueValid` edges N and N+4 at the closest). Eligible work waiting behind a busy dispatch stage issues exactly 4 cycles after the previous issue.
- R9: Each slot's age resets to 0 when it is filled and counts up by one per cycle while the slot is held. Among eligible slots, the one with the greatest age issues.
- R10: Ages saturate at 15 (4-bit counter). Among eligible slots of equal age, the first one reached scanning upward from the round-robin pointer (wrapping) wins. The pointer moves to the issued warp id plus one after every issue.
- R11: `issueValid` is a single-cycle pulse per issued instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | Fetch offers an instruction |
| fetchWarp | input | 5 | Warp id of the offered instruction |
| fetchOp | input | 8 | Opaque opcode payload |
| fetchDst | input | 4 | Destination register |
| fetchSrcA | input | 4 | First source register |
| fetchSrcB | input | 4 | Second source register |
| fetchReady | output | 1 | Slot of `fetchWarp` is empty |
| wbValid | input | 1 | Writeback report present |
| wbWarp | input | 5 | Warp id of the writeback |
| wbReg | input | 4 | Register written back |
| issueValid | output | 1 | One-cycle issue pulse |
| issueWarp | output | 5 | Warp id of the issued instruction |
| issueOp | output | 8 | Opcode of the issued instruction |
| issueDst | output | 4 | Destination register of the issued instruction |

## Verification
An instruction fetched, or unblocked by a writeback, at edge N is expected on the issue outputs right after edge N+1 when the dispatch stage is free. Work queued behind a busy dispatch stage is expected exactly 4 edges after the previous issue. The bench computes each expected issue cycle from these rules and stores it, together with the expected warp, opcode and destination, in a queue. A monitor samples the issue outputs on the falling edge and compares both the contents and the cycle count. An issue that arrives while the queue is empty fails against the requirement that the current test phase says must hold the instruction back.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;
  // Widest warp id the control-to-datapath strobe can carry.
  parameter int CTL_WARP_W = 8;

  typedef struct packed {
    logic                  fire;  // issue the selected slot at this edge
    logic [CTL_WARP_W-1:0] warp;  // slot chosen by the selection logic
  } issue_strobe_t;
endpackage

// File: rtl/warp_sched_dpath.sv
module warp_sched_dpath
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS = 24,
  parameter int NUM_REGS  = 16,
  parameter int OP_W      = 8,
  parameter int AGE_W     = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         fetchValid,
  input  logic [$clog2(NUM_WARPS)-1:0] fetchWarp,
  input  logic [OP_W-1:0]              fetchOp,
  input  logic [$clog2(NUM_REGS)-1:0]  fetchDst,
  input  logic [$clog2(NUM_REGS)-1:0]  fetchSrcA,
  input  logic [$clog2(NUM_REGS)-1:0]  fetchSrcB,
  output logic                         fetchReady,
  input  logic                         wbValid,
  input  logic [$clog2(NUM_WARPS)-1:0] wbWarp,
  input  logic [$clog2(NUM_REGS)-1:0]  wbReg,
  input  issue_strobe_t                strobe,
  output logic [NUM_WARPS-1:0]         eligVec,
  output logic [NUM_WARPS*AGE_W-1:0]   ageFlat,
  output logic                         issueValid,
  output logic [$clog2(NUM_WARPS)-1:0] issueWarp,
  output logic [OP_W-1:0]              issueOp,
  output logic [$clog2(NUM_REGS)-1:0]  issueDst
);
  localparam int WID_W = $clog2(NUM_WARPS);
  localparam int REG_W = $clog2(NUM_REGS);
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

  logic [NUM_WARPS-1:0] slotVec;
  logic [OP_W-1:0]      opArr  [NUM_WARPS];
  logic [REG_W-1:0]     dstArr [NUM_WARPS];
  logic                 inRange;
  logic [WID_W-1:0]     selIdx;

  assign inRange    = {1'b0, fetchWarp} < (WID_W+1)'(NUM_WARPS);
  assign fetchReady = inRange && !slotVec[fetchWarp];
  assign selIdx     = strobe.warp[WID_W-1:0];

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    logic                fillW, issW, wbW;
    logic                validQ;
    logic [OP_W-1:0]     opQ;
    logic [REG_W-1:0]    dstQ, srcAQ, srcBQ;
    logic [AGE_W-1:0]    ageQ;
    logic [NUM_REGS-1:0] pendQ, pendNext;

    assign fillW = fetchValid && fetchReady && (fetchWarp == WID_W'(w));
    assign issW  = strobe.fire && (strobe.warp == CTL_WARP_W'(w));
    assign wbW   = wbValid && (wbWarp == WID_W'(w));

    // Writeback clears first, issue sets last: set wins on a collision.
    always_comb begin
      pendNext = pendQ;
      if (wbW) pendNext[wbReg] = 1'b0;
      if (issW) pendNext[dstQ] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ <= 1'b0;
        ageQ   <= '0;
        pendQ  <= '0;
        opQ    <= '0;
        dstQ   <= '0;
        srcAQ  <= '0;
        srcBQ  <= '0;
      end else begin
        pendQ <= pendNext;
        if (fillW) begin
          validQ <= 1'b1;
          ageQ   <= '0;
          opQ    <= fetchOp;
          dstQ   <= fetchDst;
          srcAQ  <= fetchSrcA;
          srcBQ  <= fetchSrcB;
        end else if (issW) begin
          validQ <= 1'b0;
        end else if (validQ && ageQ != AGE_MAX) begin
          ageQ <= ageQ + 1'b1;
        end
      end
    end

    assign slotVec[w] = validQ;
    assign eligVec[w] = validQ && !pendQ[dstQ] && !pendQ[srcAQ] && !pendQ[srcBQ];
    assign ageFlat[w*AGE_W +: AGE_W] = ageQ;
    assign opArr[w]  = opQ;
    assign dstArr[w] = dstQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      issueValid <= 1'b0;
      issueWarp  <= '0;
      issueOp    <= '0;
      issueDst   <= '0;
    end else begin
      issueValid <= strobe.fire;
      if (strobe.fire) begin
        issueWarp <= selIdx;
        issueOp   <= opArr[selIdx];
        issueDst  <= dstArr[selIdx];
      end
    end
  end
endmodule

// File: rtl/warp_sched_ctrl.sv
module warp_sched_ctrl
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS   = 24,
  parameter int AGE_W       = 4,
  parameter int DISP_CYCLES = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_WARPS-1:0]       eligVec,
  input  logic [NUM_WARPS*AGE_W-1:0] ageFlat,
  output issue_strobe_t              strobe
);
  localparam int WID_W  = $clog2(NUM_WARPS);
  localparam int BUSY_W = $clog2(DISP_CYCLES + 1);

  logic [BUSY_W-1:0] busyCnt;
  logic [WID_W-1:0]  rrPtr;
  logic              found;
  int                best;
  int                idx;
  logic [AGE_W-1:0]  bestAge;
  logic [AGE_W-1:0]  curAge;

  // Scan from the round-robin pointer; only a strictly older slot displaces
  // an earlier find, so equal ages resolve in pointer order.
  always_comb begin
    found   = 1'b0;
    best    = 0;
    bestAge = '0;
    idx     = 0;
    curAge  = '0;
    for (int k = 0; k < NUM_WARPS; k++) begin
      idx    = (int'(rrPtr) + k >= NUM_WARPS) ? int'(rrPtr) + k - NUM_WARPS : int'(rrPtr) + k;
      curAge = ageFlat[idx*AGE_W +: AGE_W];
      if (eligVec[idx] && (!found || curAge > bestAge)) begin
        found   = 1'b1;
        best    = idx;
        bestAge = curAge;
      end
    end
  end

  assign strobe.fire = found && (busyCnt == '0);
  assign strobe.warp = CTL_WARP_W'(best);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt <= '0;
      rrPtr   <= '0;
    end else begin
      if (strobe.fire) begin
        busyCnt <= BUSY_W'(DISP_CYCLES - 1);
        rrPtr   <= (best + 1 >= NUM_WARPS) ? '0 : WID_W'(best + 1);
      end else if (busyCnt != '0) begin
        busyCnt <= busyCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS   = 24,
  parameter int NUM_REGS    = 16,
  parameter int OP_W        = 8,
  parameter int AGE_W       = 4,
  parameter int DISP_CYCLES = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         fetchValid,
  input  logic [$clog2(NUM_WARPS)-1:0] fetchWarp,
  input  logic [OP_W-1:0]              fetchOp,
  input  logic [$clog2(NUM_REGS)-1:0]  fetchDst,
  input  logic [$clog2(NUM_REGS)-1:0]  fetchSrcA,
  input  logic [$clog2(NUM_REGS)-1:0]  fetchSrcB,
  output logic                         fetchReady,
  input  logic                         wbValid,
  input  logic [$clog2(NUM_WARPS)-1:0] wbWarp,
  input  logic [$clog2(NUM_REGS)-1:0]  wbReg,
  output logic                         issueValid,
  output logic [$clog2(NUM_WARPS)-1:0] issueWarp,
  output logic [OP_W-1:0]              issueOp,
  output logic [$clog2(NUM_REGS)-1:0]  issueDst
);
  issue_strobe_t              strobe;
  logic [NUM_WARPS-1:0]       eligVec;
  logic [NUM_WARPS*AGE_W-1:0] ageFlat;

  warp_sched_dpath #(
    .NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS), .OP_W(OP_W), .AGE_W(AGE_W)
  ) dpath_i (
    .clk(clk), .rstN(rstN),
    .fetchValid(fetchValid), .fetchWarp(fetchWarp), .fetchOp(fetchOp),
    .fetchDst(fetchDst), .fetchSrcA(fetchSrcA), .fetchSrcB(fetchSrcB),
    .fetchReady(fetchReady),
    .wbValid(wbValid), .wbWarp(wbWarp), .wbReg(wbReg),
    .strobe(strobe), .eligVec(eligVec), .ageFlat(ageFlat),
    .issueValid(issueValid), .issueWarp(issueWarp),
    .issueOp(issueOp), .issueDst(issueDst)
  );

  warp_sched_ctrl #(
    .NUM_WARPS(NUM_WARPS), .AGE_W(AGE_W), .DISP_CYCLES(DISP_CYCLES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .eligVec(eligVec), .ageFlat(ageFlat), .strobe(strobe)
  );
endmodule

// File: rtl/warp_issue_sched_chk.sv
module warp_issue_sched_chk #(
  parameter int NUM_WARPS   = 24,
  parameter int DISP_CYCLES = 4
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         fetchValid,
  input logic [$clog2(NUM_WARPS)-1:0] fetchWarp,
  input logic                         fetchReady,
  input logic                         issueValid,
  input logic [$clog2(NUM_WARPS)-1:0] issueWarp
);
  localparam int WID_W = $clog2(NUM_WARPS);
  localparam int GAP_W = $clog2(DISP_CYCLES + 1);

  // Cycles since the last issue pulse, capped at the dispatch length.
  logic [GAP_W-1:0] gapCnt;
  always_ff @(posedge clk) begin
    if (!rstN) gapCnt <= GAP_W'(DISP_CYCLES);
    else if (issueValid) gapCnt <= GAP_W'(1);
    else if (gapCnt < GAP_W'(DISP_CYCLES)) gapCnt <= gapCnt + 1'b1;
  end

  assert_idle_after_reset_R1: assert property (@(posedge clk)
    !rstN |=> !issueValid);

  assert_slot_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && fetchReady) |=> (fetchWarp != $past(fetchWarp) || !fetchReady));

  assert_warp_in_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> ({1'b0, issueWarp} < (WID_W+1)'(NUM_WARPS)));

  assert_dispatch_gap_R8: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> (gapCnt >= GAP_W'(DISP_CYCLES)));

  assert_issue_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |=> !issueValid);
endmodule

bind warp_issue_sched warp_issue_sched_chk #(
  .NUM_WARPS(NUM_WARPS), .DISP_CYCLES(DISP_CYCLES)
) chk_i (
  .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchWarp(fetchWarp),
  .fetchReady(fetchReady), .issueValid(issueValid), .issueWarp(issueWarp)
);

// File: tb/warp_issue_sched_tb_top.sv
module warp_issue_sched_tb_top;
  localparam int NW = 24;
  localparam int NR = 16;
  localparam int WW = $clog2(NW);
  localparam int RW = $clog2(NR);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fetchValid = 1'b0;
  logic [WW-1:0] fetchWarp = '0;
  logic [7:0] fetchOp = '0;
  logic [RW-1:0] fetchDst = '0, fetchSrcA = '0, fetchSrcB = '0;
  logic fetchReady;
  logic wbValid = 1'b0;
  logic [WW-1:0] wbWarp = '0;
  logic [RW-1:0] wbReg = '0;
  logic issueValid;
  logic [WW-1:0] issueWarp;
  logic [7:0] issueOp;
  logic [RW-1:0] issueDst;

  always #2 clk = ~clk;  // 250 MHz

  warp_issue_sched dut_i (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchWarp(fetchWarp),
    .fetchOp(fetchOp), .fetchDst(fetchDst), .fetchSrcA(fetchSrcA),
    .fetchSrcB(fetchSrcB), .fetchReady(fetchReady), .wbValid(wbValid),
    .wbWarp(wbWarp), .wbReg(wbReg), .issueValid(issueValid),
    .issueWarp(issueWarp), .issueOp(issueOp), .issueDst(issueDst)
  );

  typedef struct {
    int    warp;
    int    op;
    int    dst;
    int    due;
    string tag;
  } exp_t;

  exp_t  expQ[$];
  exp_t  e;
  int    cyc = 0;
  int    nChecks = 0;
  int    nFail = 0;
  bit    finished = 0;
  string idleTag = "R1";
  logic  rdy;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic expect_issue(input int w, input int op, input int d,
                              input int due, input string tag);
    exp_t x;
    x.warp = w; x.op = op; x.dst = d; x.due = due; x.tag = tag;
    expQ.push_back(x);
  endtask

  // Monitor: compare every issue pulse against the scoreboard queue.
  always @(negedge clk) begin
    if (rstN && issueValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, idleTag, "unexpected issue from warp", int'(issueWarp), -1);
      end else begin
        e = expQ.pop_front();
        check(int'(issueWarp) == e.warp, e.tag, "issued warp", int'(issueWarp), e.warp);
        check(int'(issueOp) == e.op && int'(issueDst) == e.dst, e.tag,
              "issued op*16+dst", int'(issueOp)*16 + int'(issueDst), e.op*16 + e.dst);
        check(cyc == e.due, e.tag, "issue cycle", cyc, e.due);
      end
    end
  end

  // All drive tasks start and end on a falling edge.
  task automatic fetch(input int w, input int op, input int d, input int a, input int b);
    fetchValid = 1'b1; fetchWarp = WW'(w); fetchOp = 8'(op);
    fetchDst = RW'(d); fetchSrcA = RW'(a); fetchSrcB = RW'(b);
    @(negedge clk);
    fetchValid = 1'b0;
  endtask

  task automatic writeback(input int w, input int r);
    wbValid = 1'b1; wbWarp = WW'(w); wbReg = RW'(r);
    @(negedge clk);
    wbValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic probe_ready(input int w, output logic r);
    fetchValid = 1'b0; fetchWarp = WW'(w);
    #1;
    r = fetchReady;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      report();
    end
  end

  initial begin
    int k;
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1: reset state
    check(issueValid == 1'b0, "R1", "issueValid after reset", int'(issueValid), 0);
    probe_ready(0, rdy);  check(rdy == 1'b1, "R1", "slot 0 empty", int'(rdy), 1);
    probe_ready(23, rdy); check(rdy == 1'b1, "R1", "slot 23 empty", int'(rdy), 1);
    idle(1);

    // R3 basic issue timing, R2 slot occupancy
    idleTag = "R3";
    k = cyc;
    expect_issue(3, 'h11, 6, k + 2, "R3");
    fetch(3, 'h11, 6, 1, 2);
    probe_ready(3, rdy); check(rdy == 1'b0, "R2", "slot 3 held before issue", int'(rdy), 0);
    idle(1);
    probe_ready(3, rdy); check(rdy == 1'b1, "R2", "slot 3 empty after issue", int'(rdy), 1);
    idle(5);

    // R4 read-after-write; R2 refused fetch; R6 other warp's writeback
    idleTag = "R4";
    fetch(3, 'h22, 7, 6, 1);
    idle(6);
    probe_ready(3, rdy); check(rdy == 1'b0, "R2", "slot 3 blocked stays full", int'(rdy), 0);
    idle(1);
    fetch(3, 'h99, 8, 0, 0);  // offered to full slot: must be dropped (R2)
    idleTag = "R6";
    writeback(4, 6);
    idle(6);
    k = cyc;
    expect_issue(3, 'h22, 7, k + 2, "R4");
    writeback(3, 6);
    idle(6);
    probe_ready(3, rdy); check(rdy == 1'b1, "R2", "refused fetch left no slot", int'(rdy), 1);
    idle(1);

    // R5 write-after-write (r7 of warp 3 is pending)
    idleTag = "R5";
    fetch(3, 'h33, 7, 0, 1);
    idle(8);
    k = cyc;
    expect_issue(3, 'h33, 7, k + 2, "R5");
    writeback(3, 7);
    idle(6);

    // R7 set wins over a same-edge clear
    idleTag = "R7";
    k = cyc;
    expect_issue(5, 'h44, 2, k + 2, "R7");
    fetch(5, 'h44, 2, 0, 1);
    writeback(5, 2);          // lands on the issue edge
    idle(4);
    fetch(5, 'h55, 9, 2, 3);  // reads r2, must stay blocked
    idle(8);
    k = cyc;
    expect_issue(5, 'h55, 9, k + 2, "R7");
    writeback(5, 2);
    idle(6);

    // R8 dispatch occupancy with back-to-back work
    idleTag = "R8";
    k = cyc;
    expect_issue(0, 'h60, 10, k + 2, "R8");
    expect_issue(1, 'h61, 10, k + 6, "R8");
    expect_issue(2, 'h62, 10, k + 10, "R8");
    fetch(0, 'h60, 10, 0, 1);
    fetch(1, 'h61, 10, 0, 1);
    fetch(2, 'h62, 10, 0, 1);
    idle(12);

    // R9 older slot beats round-robin order (pointer at 1 after warp 0)
    idleTag = "R9";
    k = cyc;
    expect_issue(0, 'h70, 11, k + 2, "R9");
    expect_issue(9, 'h71, 11, k + 6, "R9");
    expect_issue(2, 'h72, 11, k + 10, "R9");
    fetch(0, 'h70, 11, 0, 1);
    fetch(9, 'h71, 11, 0, 1);
    fetch(2, 'h72, 11, 0, 1);
    idle(12);

    // R10 saturated ages tie; pointer after warp 6 is 7
    idleTag = "R10";
    k = cyc;
    expect_issue(4, 'h80, 12, k + 2, "R10");
    fetch(4, 'h80, 12, 0, 1);
    idle(5);
    k = cyc;
    expect_issue(7, 'h81, 12, k + 2, "R10");
    fetch(7, 'h81, 12, 0, 1);
    idle(5);
    fetch(4, 'h82, 13, 12, 0);
    fetch(7, 'h83, 13, 12, 0);
    idle(24);
    k = cyc;
    expect_issue(6, 'h84, 14, k + 2, "R10");
    expect_issue(7, 'h83, 13, k + 6, "R10");
    expect_issue(4, 'h82, 13, k + 10, "R10");
    fetch(6, 'h84, 14, 0, 1);
    writeback(4, 12);
    writeback(7, 12);
    idle(14);

    check(expQ.size() == 0, "R3", "issues still outstanding", expQ.size(), 0);
    finished = 1;
    report();
  end
endmodule